// File: doc/BRIEF.md
# Masked packed integer narrowing unit

This block narrows a vector of 64-bit integer lanes into 32-bit lanes in one registered step. An opcode byte picks one of three conversions: keep the low half of each lane, clamp as signed, or clamp as unsigned. A two-bit length code sets the source length to 128, 256 or 512 bits, that is 2, 4 or 8 lanes. Converted lanes are packed from the least-significant 32-bit word upward.

A per-lane write mask, qualified by a mask enable, decides which lanes take their converted value. For a register destination, a masked-off lane is cleared or keeps the previous destination value, as the zeroing select says, and every result bit above the packed lanes is cleared. For a memory destination, masked-off lanes are always merged, and per-lane write enables tell the store path which 32-bit words to write. A bad reserved field, an unknown opcode, or a length longer than the configured maximum raises an illegal flag and blocks every write.

Top module: `lane_narrow_unit`

## Requirements
- R1: Opcode 8'h35 selects truncation: an active lane's 32-bit result equals the low 32 bits of its 64-bit source lane.
- R2: Opcode 8'h25 selects signed saturation: a lane read as signed above 2^31-1 gives 32'h7FFFFFFF, one below -2^31 gives 32'h80000000, and any other value passes its low 32 bits.
- R3: Opcode 8'h15 selects unsigned saturation: a lane read as unsigned above 2^32-1 gives 32'hFFFFFFFF, and any other value passes its low 32 bits.
- R4: Length code 0, 1, 2 and 3 mean 2, 4, 8 and 16 lanes. Result lane j occupies bits j*32+31..j*32 and comes from source bits j*64+63..j*64. With masking off, a memory destination raises the write enable of exactly the lanes below the lane count.
- R5: A lane is active when mask_en is 0 or its lane_mask bit is 1. Only active lanes can have a write enable raised.
- R6: Register destination (mem_dst=0): a lane below the lane count that is not active is 0 when zero_sel=1, and holds the matching 32-bit word of prev_dst when zero_sel=0.
- R7: Memory destination (mem_dst=1): an inactive lane below the lane count carries the prev_dst word whatever zero_sel is, and lane_we[j] is 1 exactly for active lanes below the lane count. In the register form, every lane_we bit is 0.
- R8: Every result bit at or above lane count * 32, up to the full MAX_VL width, is 0.
- R9: resv_field other than 4'hF, an opcode outside {8'h35, 8'h25, 8'h15}, or a lane count above MAX_VL/64 sets illegal, with result all zero and lane_we all zero.
- R10: Reset clears out_valid, result, lane_we and illegal. out_valid is in_valid delayed by one clock. The outputs load only on a clock where in_valid is 1 and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this clock |
| opcode | input | 8 | Conversion select byte |
| resv_field | input | 4 | Reserved register field, must be 4'hF |
| len_code | input | 2 | Source length code (0: 128, 1: 256, 2: 512 bits) |
| src_vec | input | MAX_VL | Source vector of 64-bit lanes |
| lane_mask | input | MAX_VL/64 | Per-lane write mask |
| mask_en | input | 1 | 1 applies lane_mask, 0 treats all lanes as active |
| zero_sel | input | 1 | Register form: 1 clears masked-off lanes, 0 merges |
| mem_dst | input | 1 | 1 for a memory destination, 0 for a register |
| prev_dst | input | MAX_VL | Previous destination contents |
| out_valid | output | 1 | Result valid |
| result | output | MAX_VL | Packed 32-bit results |
| lane_we | output | MAX_VL/64 | Per-lane write enables for the memory form |
| illegal | output | 1 | Illegal encoding flag |

## Verification
The bench builds the unit with MAX_VL=256, so there are four lanes. Every mask value can then be swept for every opcode, length code, mask enable, zeroing select and destination kind. In this configuration the 512-bit length code is longer than the unit can hold, which brings the illegal-length path within reach next to the bad-opcode and reserved-field cases. Source lanes cycle through the values on either side of the signed and unsigned 32-bit limits, and the bench computes the clamped results from plain integer comparisons.

// File: rtl/narrow_pkg.sv
package narrow_pkg;

    typedef enum logic [1:0] {
        NM_TRUNC = 2'd0,
        NM_SSAT  = 2'd1,
        NM_USAT  = 2'd2,
        NM_BAD   = 2'd3
    } narrow_mode_e;

    localparam logic [7:0] OPC_TRUNC = 8'h35;
    localparam logic [7:0] OPC_SSAT  = 8'h25;
    localparam logic [7:0] OPC_USAT  = 8'h15;
    localparam logic [3:0] RESV_OK   = 4'hF;

    typedef struct packed {
        narrow_mode_e mode;
        logic         legal;
    } narrow_cmd_t;

    function automatic narrow_mode_e opc_to_mode(input logic [7:0] opc);
        case (opc)
            OPC_TRUNC: return NM_TRUNC;
            OPC_SSAT:  return NM_SSAT;
            OPC_USAT:  return NM_USAT;
            default:   return NM_BAD;
        endcase
    endfunction

    // Lane count for a length code: 2, 4, 8 or 16.
    function automatic int unsigned len_to_lanes(input logic [1:0] code);
        return 32'd2 << code;
    endfunction

endpackage

// File: rtl/narrow_decode.sv
module narrow_decode
    import narrow_pkg::*;
#(
    parameter int unsigned MAX_LANES = 8
) (
    input  logic [7:0]           opcode,
    input  logic [3:0]           resv_field,
    input  logic [1:0]           len_code,
    output narrow_cmd_t          cmd,
    output logic [MAX_LANES-1:0] lane_in_range
);

    int unsigned lane_cnt;

    always_comb begin
        lane_cnt  = len_to_lanes(len_code);
        cmd.mode  = opc_to_mode(opcode);
        cmd.legal = (resv_field == RESV_OK) && (cmd.mode != NM_BAD)
                    && (lane_cnt <= MAX_LANES);
        for (int unsigned j = 0; j < MAX_LANES; j++) begin
            lane_in_range[j] = (j < lane_cnt);
        end
    end

endmodule

// File: rtl/narrow_lane.sv
module narrow_lane
    import narrow_pkg::*;
#(
    parameter int unsigned SRC_W = 64,
    parameter int unsigned DST_W = 32
) (
    input  narrow_mode_e     mode,
    input  logic [SRC_W-1:0] src,
    input  logic [DST_W-1:0] prev,
    input  logic             legal,
    input  logic             in_range,
    input  logic             active,
    input  logic             mem_dst,
    input  logic             zero_sel,
    output logic [DST_W-1:0] res,
    output logic             we
);

    localparam int unsigned HI_W = SRC_W - DST_W + 1;
    localparam logic [DST_W-1:0] POS_MAX = {1'b0, {(DST_W-1){1'b1}}};
    localparam logic [DST_W-1:0] NEG_MIN = {1'b1, {(DST_W-1){1'b0}}};

    logic [HI_W-1:0]  sign_span;
    logic             fits_signed;
    logic             fits_unsigned;
    logic [DST_W-1:0] conv;

    // Converter: the bits from the kept sign bit upward must all match for
    // a signed fit; every bit above the kept half must be 0 for an unsigned fit.
    always_comb begin
        sign_span     = src[SRC_W-1:DST_W-1];
        fits_signed   = (sign_span == '0) || (sign_span == '1);
        fits_unsigned = (src[SRC_W-1:DST_W] == '0);
        case (mode)
            NM_TRUNC: conv = src[DST_W-1:0];
            NM_SSAT:  conv = fits_signed ? src[DST_W-1:0]
                                         : (src[SRC_W-1] ? NEG_MIN : POS_MAX);
            NM_USAT:  conv = fits_unsigned ? src[DST_W-1:0] : '1;
            default:  conv = '0;
        endcase
    end

    // Mask and destination policy.
    always_comb begin
        if (!legal || !in_range) begin
            res = '0;
        end else if (active) begin
            res = conv;
        end else if (mem_dst || !zero_sel) begin
            res = prev;
        end else begin
            res = '0;
        end
        we = legal && in_range && active && mem_dst;
    end

endmodule

// File: rtl/lane_narrow_unit.sv
module lane_narrow_unit
    import narrow_pkg::*;
#(
    parameter int unsigned MAX_VL = 512,
    parameter int unsigned SRC_W  = 64,
    parameter int unsigned DST_W  = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [7:0]                  opcode,
    input  logic [3:0]                  resv_field,
    input  logic [1:0]                  len_code,
    input  logic [MAX_VL-1:0]           src_vec,
    input  logic [MAX_VL/SRC_W-1:0]     lane_mask,
    input  logic                        mask_en,
    input  logic                        zero_sel,
    input  logic                        mem_dst,
    input  logic [MAX_VL-1:0]           prev_dst,
    output logic                        out_valid,
    output logic [MAX_VL-1:0]           result,
    output logic [MAX_VL/SRC_W-1:0]     lane_we,
    output logic                        illegal
);

    localparam int unsigned MAX_LANES = MAX_VL / SRC_W;

    narrow_cmd_t            cmd;
    logic [MAX_LANES-1:0]   lane_in_range;
    logic [MAX_LANES-1:0]   lane_active;
    logic [MAX_LANES-1:0]   we_nxt;
    logic [DST_W-1:0]       lane_res [MAX_LANES];
    logic [MAX_VL-1:0]      result_nxt;

    narrow_decode #(.MAX_LANES(MAX_LANES)) u_decode (
        .opcode        (opcode),
        .resv_field    (resv_field),
        .len_code      (len_code),
        .cmd           (cmd),
        .lane_in_range (lane_in_range)
    );

    assign lane_active = mask_en ? lane_mask : '1;

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        narrow_lane #(.SRC_W(SRC_W), .DST_W(DST_W)) u_lane (
            .mode     (cmd.mode),
            .src      (src_vec[j*SRC_W +: SRC_W]),
            .prev     (prev_dst[j*DST_W +: DST_W]),
            .legal    (cmd.legal),
            .in_range (lane_in_range[j]),
            .active   (lane_active[j]),
            .mem_dst  (mem_dst),
            .zero_sel (zero_sel),
            .res      (lane_res[j]),
            .we       (we_nxt[j])
        );
    end

    // Pack from the least-significant word; the upper half stays zero.
    always_comb begin
        result_nxt = '0;
        for (int j = 0; j < int'(MAX_LANES); j++) begin
            result_nxt[j*DST_W +: DST_W] = lane_res[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            lane_we   <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= result_nxt;
                lane_we <= we_nxt;
                illegal <= !cmd.legal;
            end
        end
    end

endmodule

// File: rtl/narrow_unit_checks.sv
module narrow_unit_checks #(
    parameter int unsigned MAX_VL = 512,
    parameter int unsigned LANES  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [3:0]        resv_field,
    input logic [LANES-1:0]  lane_mask,
    input logic              mask_en,
    input logic              mem_dst,
    input logic              out_valid,
    input logic [MAX_VL-1:0] result,
    input logic [LANES-1:0]  lane_we,
    input logic              illegal
);

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drops_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(lane_we) && $stable(illegal)));

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (lane_we == '0 && result == '0));

    assert_bad_resv_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && resv_field != 4'hF) |=> illegal);

    assert_reg_no_we_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mem_dst) |=> (lane_we == '0));

    assert_we_in_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en) |=> ((lane_we & ~$past(lane_mask)) == '0));

endmodule

bind lane_narrow_unit narrow_unit_checks #(.MAX_VL(MAX_VL), .LANES(MAX_LANES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .resv_field (resv_field),
    .lane_mask  (lane_mask),
    .mask_en    (mask_en),
    .mem_dst    (mem_dst),
    .out_valid  (out_valid),
    .result     (result),
    .lane_we    (lane_we),
    .illegal    (illegal)
);

// File: tb/lane_narrow_unit_test.sv
module lane_narrow_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_VL     = 256;
    localparam int LANES      = MAX_VL / 64;
    localparam int WORDS      = MAX_VL / 32;
    localparam longint S_MAX  = 64'sh7FFFFFFF;
    localparam longint S_MIN  = -64'sh80000000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [7:0]        opcode = 8'h35;
    logic [3:0]        resv_field = 4'hF;
    logic [1:0]        len_code = 2'd0;
    logic [MAX_VL-1:0] src_vec = '0;
    logic [LANES-1:0]  lane_mask = '0;
    logic              mask_en = 1'b0;
    logic              zero_sel = 1'b0;
    logic              mem_dst = 1'b0;
    logic [MAX_VL-1:0] prev_dst = '0;
    logic              out_valid;
    logic [MAX_VL-1:0] result;
    logic [LANES-1:0]  lane_we;
    logic              illegal;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_narrow_unit #(.MAX_VL(MAX_VL)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .resv_field(resv_field), .len_code(len_code), .src_vec(src_vec),
        .lane_mask(lane_mask), .mask_en(mask_en), .zero_sel(zero_sel),
        .mem_dst(mem_dst), .prev_dst(prev_dst), .out_valid(out_valid),
        .result(result), .lane_we(lane_we), .illegal(illegal)
    );

    function automatic logic [63:0] pick_val(input int k);
        case (k % 11)
            0:  return 64'h0000_0000_0000_0000;
            1:  return 64'h0000_0000_7FFF_FFFF;
            2:  return 64'h0000_0000_8000_0000;
            3:  return 64'h0000_0000_FFFF_FFFF;
            4:  return 64'h0000_0001_0000_0000;
            5:  return 64'hFFFF_FFFF_FFFF_FFFF;
            6:  return 64'hFFFF_FFFF_8000_0000;
            7:  return 64'hFFFF_FFFF_7FFF_FFFF;
            8:  return 64'h8000_0000_0000_0000;
            9:  return 64'h7FFF_FFFF_FFFF_FFFF;
            default: return 64'h0000_0123_4567_89AB;
        endcase
    endfunction

    function automatic logic [7:0] op_byte(input int op);
        case (op)
            0: return 8'h35;
            1: return 8'h25;
            2: return 8'h15;
            default: return 8'h45;
        endcase
    endfunction

    function automatic logic [31:0] exp_conv(input int op, input logic [63:0] v);
        longint          s = v;
        longint unsigned u = v;
        if (op == 1) begin
            if (s > S_MAX) return 32'h7FFF_FFFF;
            if (s < S_MIN) return 32'h8000_0000;
            return v[31:0];
        end
        if (op == 2) begin
            if (u > 64'hFFFF_FFFF) return 32'hFFFF_FFFF;
            return v[31:0];
        end
        return v[31:0];
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [MAX_VL-1:0] act, input logic [MAX_VL-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one operation, then check the registered outputs one clock later.
    task automatic run_op(input int op, input int vsel, input int m, input int ctl,
                          input logic [3:0] rv, input int seed);
        logic [MAX_VL-1:0] e_res;
        logic [LANES-1:0]  e_we;
        logic [MAX_VL-1:0] upper;
        int  kl;
        bit  bad, men, zs, mem;
        string tag_r, tag_w;
        men = ctl[0]; zs = ctl[1]; mem = ctl[2];
        kl  = 2 << vsel;
        bad = (rv != 4'hF) || (op == 3) || (kl > LANES);
        @(negedge clk);
        opcode = op_byte(op); resv_field = rv; len_code = vsel[1:0];
        lane_mask = m[LANES-1:0]; mask_en = men; zero_sel = zs; mem_dst = mem;
        for (int j = 0; j < LANES; j++) src_vec[j*64 +: 64] = pick_val(seed + j*3);
        for (int w = 0; w < WORDS; w++) prev_dst[w*32 +: 32] = 32'hC0DE_0000 + seed*8 + w;
        in_valid = 1'b1;
        e_res = '0; e_we = '0; upper = '0;
        for (int j = 0; j < LANES; j++) begin
            if (!bad && j < kl) begin
                if (!men || m[j]) begin
                    e_res[j*32 +: 32] = exp_conv(op, src_vec[j*64 +: 64]);
                    e_we[j] = mem;
                end else if (mem || !zs) begin
                    e_res[j*32 +: 32] = prev_dst[j*32 +: 32];
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (bad) tag_r = "R9";
        else if (!men) tag_r = (op == 0) ? "R1" : (op == 1) ? "R2" : "R3";
        else tag_r = mem ? "R7" : "R6";
        tag_w = bad ? "R9" : !mem ? "R7" : men ? "R5" : "R4";
        chk("R10", "out_valid", MAX_VL'(out_valid), MAX_VL'(1'b1));
        chk("R9", "illegal", MAX_VL'(illegal), MAX_VL'(bad));
        chk(tag_r, "result", result, e_res);
        chk(tag_w, "lane_we", MAX_VL'(lane_we), MAX_VL'(e_we));
        if (!bad && !mem) begin
            for (int b = 0; b < MAX_VL; b++) upper[b] = (b >= kl*32) ? result[b] : 1'b0;
            chk("R8", "upper bits", upper, '0);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 60000);
        n_errors++;
        $display("FAIL R10 watchdog: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        logic [MAX_VL-1:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10", "reset out_valid", MAX_VL'(out_valid), '0);
        chk("R10", "reset result", result, '0);
        chk("R10", "reset lane_we", MAX_VL'(lane_we), '0);
        chk("R10", "reset illegal", MAX_VL'(illegal), '0);

        for (int op = 0; op < 4; op++)
            for (int vsel = 0; vsel < 4; vsel++)
                for (int m = 0; m < (1 << LANES); m++)
                    for (int ctl = 0; ctl < 8; ctl++)
                        run_op(op, vsel, m, ctl, 4'hF, op*7 + vsel*5 + m + ctl);

        for (int rv = 0; rv < 15; rv++)
            run_op(rv % 3, 1, 4'hF, 4 + (rv % 2), rv[3:0], rv);

        // Hold: with no new operation the outputs keep their value.
        run_op(1, 1, 4'b0101, 3, 4'hF, 9);
        held = result;
        @(negedge clk);
        chk("R10", "idle out_valid", MAX_VL'(out_valid), '0);
        chk("R10", "idle hold result", result, held);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule